// File: doc/BRIEF.md
# Debug Port Control and Status Block

This block is the register layer between a serial debug transport and the access ports behind it. The transport decodes each incoming packet into read and write strobes for two registers: a control/status word and an access-port select word. The control/status word drives power-up requests to the debug and system power domains. It shows the acknowledges that come back, brought into the debug clock domain through two synchronising flops.

The block also polices pipelined access-port traffic. Software sets an overrun-detect enable once both power acknowledges have been seen. From then on, an access-port request that arrives while the access port still reports busy is refused and sets a sticky overrun flag. While that flag is set, every later access-port request is refused: the transport receives a fault response and nothing is issued to the access port. Software clears the flag by writing a one to its bit. The select word carries the index of the access port that later transactions address.

Top module: `dbg_port_ctl`

## Requirements
- R1: After reset the overrun enable, the sticky flag, both power request outputs and the select index are zero, and `ap_en` is 1.
- R2: A control/status write loads the overrun enable from bit 0, the debug power request from bit 4 and the system power request from bit 6. `pwr_dbg_req` and `pwr_sys_req` follow from the next clock edge, and the bits hold while no write occurs.
- R3: The debug and system acknowledges read back on control/status bits 5 and 7. A change on an acknowledge input first shows on the read port after the second rising clock edge.
- R4: A select write stores bits 31:24 as the access-port index on `ap_index`. A select read returns the index in bits 31:24 and zero elsewhere.
- R5: While the sticky flag is clear, an access-port request with the access port idle (or with overrun detection off) raises `ap_go` in the same cycle and leaves `ap_fault` low.
- R6: With overrun detection on, a request while `ap_busy` is high raises `ap_fault` rather than `ap_go`. From the next edge the sticky flag reads 1 at control/status bit 1 and `ap_en` is 0.
- R7: While the sticky flag is set, every access-port request raises `ap_fault` and never `ap_go`, whatever `ap_busy` is.
- R8: A control/status write with bit 1 set clears the sticky flag. A write with bit 1 clear leaves it unchanged.
- R9: With overrun detection off, a request during busy is passed to the access port and does not set the sticky flag.
- R10: When an overrun event and a clearing write occur in the same cycle, the sticky flag is set afterwards.
- R11: `rdata` is zero in any cycle with no read strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Debug clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| csr_wr | input | 1 | Control/status write strobe |
| csr_rd | input | 1 | Control/status read strobe |
| sel_wr | input | 1 | Select write strobe |
| sel_rd | input | 1 | Select read strobe |
| wdata | input | 32 | Write data from the transport |
| rdata | output | 32 | Read data to the transport |
| ap_req | input | 1 | Access-port transaction request from the transport |
| ap_busy | input | 1 | Access port still working on the previous transaction |
| ap_go | output | 1 | Transaction issued to the access port |
| ap_fault | output | 1 | Request refused; fault response to the transport |
| ap_en | output | 1 | Access-port operations permitted (no sticky flag) |
| ap_index | output | 8 | Selected access-port index |
| pwr_dbg_ack | input | 1 | Debug power domain acknowledge (asynchronous) |
| pwr_sys_ack | input | 1 | System power domain acknowledge (asynchronous) |
| pwr_dbg_req | output | 1 | Debug power domain request |
| pwr_sys_req | output | 1 | System power domain request |

## Verification
A wrong sticky flag shows at once. Requests fault or go on the same cycle they arrive, so a flag that is lost or set in error changes `ap_go`/`ap_fault` on the very next request, and `ap_en` changes one edge after the event. A synchroniser of the wrong depth shifts the cycle in which an acknowledge appears on the read port by one edge, so the bench reads the register every cycle around each acknowledge change. Random mixes of busy, request and clearing writes cover set-and-clear collisions. Directed sequences pin the power-up order and the select field position.

// File: rtl/dpc_pkg.sv
package dpc_pkg;

   localparam int CSR_OVR_EN  = 0;
   localparam int CSR_STICKY  = 1;
   localparam int CSR_DBG_REQ = 4;
   localparam int CSR_DBG_ACK = 5;
   localparam int CSR_SYS_REQ = 6;
   localparam int CSR_SYS_ACK = 7;
   localparam int CSR_MIN_W   = 8;

   typedef struct packed {
      logic sys_req;
      logic dbg_req;
      logic ovr_en;
   } dpc_ctl_t;

endpackage

// File: rtl/dpc_ack_sync.sv
module dpc_ack_sync #(
   parameter int STAGES = 2,
   parameter int W      = 2
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] async_i,
   output logic [W-1:0] sync_o
);

   generate
      if (STAGES < 0) begin : g_bad
         initial $error("dpc_ack_sync: STAGES must not be negative");
      end

      if (STAGES == 0) begin : g_pass
         assign sync_o = async_i;
      end else begin : g_chain
         logic [STAGES-1:0][W-1:0] q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) q[0] <= '0;
            else        q[0] <= async_i;
         end
         for (genvar s = 1; s < STAGES; s++) begin : g_stage
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n) q[s] <= '0;
               else        q[s] <= q[s-1];
            end
         end
         assign sync_o = q[STAGES-1];
      end
   endgenerate

endmodule

// File: rtl/dpc_ctl_regs.sv
module dpc_ctl_regs
   import dpc_pkg::*;
#(
   parameter int DATA_W  = 32,
   parameter int SEL_W   = 8,
   parameter int SEL_LSB = 24
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              csr_wr,
   input  logic              csr_rd,
   input  logic              sel_wr,
   input  logic              sel_rd,
   input  logic [DATA_W-1:0] wdata,
   input  logic              sticky,
   input  logic              dbg_ack_s,
   input  logic              sys_ack_s,
   output dpc_ctl_t          ctl,
   output logic [SEL_W-1:0]  ap_sel,
   output logic              clr_sticky,
   output logic [DATA_W-1:0] rdata
);

   generate
      if (DATA_W < CSR_MIN_W) begin : g_bad_w
         initial $error("dpc_ctl_regs: DATA_W too narrow for the control word");
      end
      if (SEL_LSB + SEL_W > DATA_W) begin : g_bad_sel
         initial $error("dpc_ctl_regs: select field exceeds DATA_W");
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ctl <= '0;
      end else if (csr_wr) begin
         ctl.ovr_en  <= wdata[CSR_OVR_EN];
         ctl.dbg_req <= wdata[CSR_DBG_REQ];
         ctl.sys_req <= wdata[CSR_SYS_REQ];
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      ap_sel <= '0;
      else if (sel_wr) ap_sel <= wdata[SEL_LSB +: SEL_W];
   end

   assign clr_sticky = csr_wr & wdata[CSR_STICKY];

   always_comb begin
      rdata = '0;
      if (csr_rd) begin
         rdata[CSR_OVR_EN]  = ctl.ovr_en;
         rdata[CSR_STICKY]  = sticky;
         rdata[CSR_DBG_REQ] = ctl.dbg_req;
         rdata[CSR_DBG_ACK] = dbg_ack_s;
         rdata[CSR_SYS_REQ] = ctl.sys_req;
         rdata[CSR_SYS_ACK] = sys_ack_s;
      end else if (sel_rd) begin
         rdata[SEL_LSB +: SEL_W] = ap_sel;
      end
   end

   // R2
   ctl_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !csr_wr |=> $stable(ctl));

   // R4
   sel_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !sel_wr |=> $stable(ap_sel));

   // R11
   idle_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!csr_rd && !sel_rd) |-> (rdata == '0));

endmodule

// File: rtl/dpc_overrun.sv
module dpc_overrun (
   input  logic clk,
   input  logic rst_n,
   input  logic ap_req,
   input  logic ap_busy,
   input  logic ovr_en,
   input  logic clr,
   output logic sticky,
   output logic ap_go,
   output logic ap_fault
);

   logic ovr_event;

   assign ovr_event = ap_req & ovr_en & ap_busy;
   assign ap_fault  = ap_req & (sticky | ovr_event);
   assign ap_go     = ap_req & ~ap_fault;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)         sticky <= 1'b0;
      else if (ovr_event) sticky <= 1'b1;
      else if (clr)       sticky <= 1'b0;
   end

   // R6
   ovr_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (ap_req && ovr_en && ap_busy) |=> sticky);

   // R7
   blocked_chk: assert property (@(posedge clk) disable iff (!rst_n)
      sticky |-> !ap_go);

   // R8
   sticky_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (sticky && !clr) |=> sticky);

   // R9
   no_spurious_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!sticky && !(ap_req && ovr_en)) |=> !sticky);

endmodule

// File: rtl/dbg_port_ctl.sv
module dbg_port_ctl
   import dpc_pkg::*;
#(
   parameter int DATA_W      = 32,
   parameter int SEL_W       = 8,
   parameter int SEL_LSB     = 24,
   parameter int SYNC_STAGES = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              csr_wr,
   input  logic              csr_rd,
   input  logic              sel_wr,
   input  logic              sel_rd,
   input  logic [DATA_W-1:0] wdata,
   output logic [DATA_W-1:0] rdata,
   input  logic              ap_req,
   input  logic              ap_busy,
   output logic              ap_go,
   output logic              ap_fault,
   output logic              ap_en,
   output logic [SEL_W-1:0]  ap_index,
   input  logic              pwr_dbg_ack,
   input  logic              pwr_sys_ack,
   output logic              pwr_dbg_req,
   output logic              pwr_sys_req
);

   localparam int ACK_W = 2;

   dpc_ctl_t         ctl;
   logic             sticky;
   logic             clr_sticky;
   logic [ACK_W-1:0] ack_s;

   dpc_ack_sync #(.STAGES(SYNC_STAGES), .W(ACK_W)) u_sync (
      .clk     (clk),
      .rst_n   (rst_n),
      .async_i ({pwr_sys_ack, pwr_dbg_ack}),
      .sync_o  (ack_s)
   );

   dpc_ctl_regs #(.DATA_W(DATA_W), .SEL_W(SEL_W), .SEL_LSB(SEL_LSB)) u_regs (
      .clk        (clk),
      .rst_n      (rst_n),
      .csr_wr     (csr_wr),
      .csr_rd     (csr_rd),
      .sel_wr     (sel_wr),
      .sel_rd     (sel_rd),
      .wdata      (wdata),
      .sticky     (sticky),
      .dbg_ack_s  (ack_s[0]),
      .sys_ack_s  (ack_s[1]),
      .ctl        (ctl),
      .ap_sel     (ap_index),
      .clr_sticky (clr_sticky),
      .rdata      (rdata)
   );

   dpc_overrun u_ovr (
      .clk      (clk),
      .rst_n    (rst_n),
      .ap_req   (ap_req),
      .ap_busy  (ap_busy),
      .ovr_en   (ctl.ovr_en),
      .clr      (clr_sticky),
      .sticky   (sticky),
      .ap_go    (ap_go),
      .ap_fault (ap_fault)
   );

   assign pwr_dbg_req = ctl.dbg_req;
   assign pwr_sys_req = ctl.sys_req;
   assign ap_en       = ~sticky;

   // R5
   go_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (ap_req && ap_en && !ap_busy) |-> (ap_go && !ap_fault));

   // R10
   set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (ap_req && ap_busy && ctl.ovr_en && clr_sticky) |=> !ap_en);

endmodule

// File: tb/test_dbg_port_ctl.sv
module test_dbg_port_ctl;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        csr_wr = 0, csr_rd = 0, sel_wr = 0, sel_rd = 0;
   logic [31:0] wdata = '0;
   logic [31:0] rdata;
   logic        ap_req = 0, ap_busy = 0;
   logic        ap_go, ap_fault, ap_en;
   logic [7:0]  ap_index;
   logic        pwr_dbg_ack = 0, pwr_sys_ack = 0;
   logic        pwr_dbg_req, pwr_sys_req;

   int n_chk = 0;
   int n_fail = 0;
   string tag = "R1";

   // model state
   logic m_ovr = 0, m_sticky = 0, m_dreq = 0, m_sreq = 0;
   logic [7:0] m_sel = '0;
   logic m_d1 = 0, m_d2 = 0, m_s1 = 0, m_s2 = 0;

   always #10 clk = ~clk;

   dbg_port_ctl i_dbg_port_ctl (
      .clk(clk), .rst_n(rst_n),
      .csr_wr(csr_wr), .csr_rd(csr_rd), .sel_wr(sel_wr), .sel_rd(sel_rd),
      .wdata(wdata), .rdata(rdata),
      .ap_req(ap_req), .ap_busy(ap_busy),
      .ap_go(ap_go), .ap_fault(ap_fault), .ap_en(ap_en), .ap_index(ap_index),
      .pwr_dbg_ack(pwr_dbg_ack), .pwr_sys_ack(pwr_sys_ack),
      .pwr_dbg_req(pwr_dbg_req), .pwr_sys_req(pwr_sys_req)
   );

   function automatic logic [31:0] exp_rdata();
      logic [31:0] v = '0;
      if (csr_rd) begin
         v[0] = m_ovr; v[1] = m_sticky; v[4] = m_dreq;
         v[5] = m_d2;  v[6] = m_sreq;   v[7] = m_s2;
      end else if (sel_rd) begin
         v[31:24] = m_sel;
      end
      return v;
   endfunction

   function automatic logic exp_fault();
      return ap_req & (m_sticky | (m_ovr & ap_busy));
   endfunction

   task automatic chk(string what, logic [31:0] act, logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
      end
   endtask

   // inputs are set after a falling edge; check just before the rising edge,
   // then advance the model across that edge
   task automatic step();
      logic f;
      #5;
      f = exp_fault();
      chk("ap_fault", {31'b0, ap_fault}, {31'b0, f});
      chk("ap_go", {31'b0, ap_go}, {31'b0, ap_req & ~f});
      chk("ap_en", {31'b0, ap_en}, {31'b0, ~m_sticky});
      chk("pwr_dbg_req", {31'b0, pwr_dbg_req}, {31'b0, m_dreq});
      chk("pwr_sys_req", {31'b0, pwr_sys_req}, {31'b0, m_sreq});
      chk("ap_index", {24'b0, ap_index}, {24'b0, m_sel});
      chk("rdata", rdata, exp_rdata());
      @(posedge clk);
      if (ap_req & m_ovr & ap_busy) m_sticky = 1'b1;
      else if (csr_wr & wdata[1])   m_sticky = 1'b0;
      if (csr_wr) begin
         m_ovr = wdata[0]; m_dreq = wdata[4]; m_sreq = wdata[6];
      end
      if (sel_wr) m_sel = wdata[31:24];
      m_d2 = m_d1; m_d1 = pwr_dbg_ack;
      m_s2 = m_s1; m_s1 = pwr_sys_ack;
      @(negedge clk);
      csr_wr = 0; csr_rd = 0; sel_wr = 0; sel_rd = 0; ap_req = 0; wdata = '0;
   endtask

   task automatic wr_csr(logic [31:0] d);
      csr_wr = 1; wdata = d; step();
   endtask

   initial begin
      #(20 * 100000);
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

   initial begin
      void'($urandom(32'd1234));
      repeat (3) @(negedge clk);
      // R1: reset state
      tag = "R1";
      csr_rd = 1; step();
      rst_n = 1;
      csr_rd = 1; step();
      sel_rd = 1; step();

      // R2: power-up requests
      tag = "R2";
      wr_csr(32'h0000_0010);
      csr_rd = 1; step();
      wr_csr(32'h0000_0050);
      csr_rd = 1; step();
      step();

      // R3: acknowledges appear after two edges
      tag = "R3";
      pwr_dbg_ack = 1;
      csr_rd = 1; step();
      csr_rd = 1; step();
      csr_rd = 1; step();
      pwr_sys_ack = 1;
      csr_rd = 1; step();
      csr_rd = 1; step();
      csr_rd = 1; step();

      // R4: select field
      tag = "R4";
      sel_wr = 1; wdata = 32'hA5FF_FFFF; step();
      sel_rd = 1; step();
      sel_wr = 1; wdata = 32'h3C00_0000; step();
      sel_rd = 1; step();

      // R5 / R9: passing requests, detection off
      tag = "R5";
      ap_req = 1; step();
      tag = "R9";
      ap_req = 1; ap_busy = 1; step();
      csr_rd = 1; step();

      // R6: overrun with detection on
      tag = "R6";
      wr_csr(32'h0000_0051);
      ap_req = 1; ap_busy = 1; step();
      csr_rd = 1; step();

      // R7: blocked while sticky, busy low
      tag = "R7";
      ap_busy = 0;
      ap_req = 1; step();
      ap_req = 1; step();

      // R8: write without clear bit keeps, with clear bit clears
      tag = "R8";
      wr_csr(32'h0000_0051);
      csr_rd = 1; step();
      wr_csr(32'h0000_0053);
      csr_rd = 1; step();
      ap_req = 1; step();

      // R10: overrun and clear in the same cycle
      tag = "R10";
      ap_busy = 1; ap_req = 1; csr_wr = 1; wdata = 32'h0000_0053; step();
      csr_rd = 1; step();
      wr_csr(32'h0000_0053);
      ap_busy = 0;

      // R11 plus random mix covering R5 R6 R7 R8 R9 R10
      tag = "R11";
      step();
      tag = "R5 R6 R7 R8 R9 R10 R11";
      for (int i = 0; i < 400; i++) begin
         ap_req  = ($urandom % 2) == 0;
         ap_busy = ($urandom % 3) == 0;
         if (($urandom % 6) == 0) begin
            csr_wr = 1;
            wdata = $urandom & 32'h0000_00F3;
         end
         if (($urandom % 10) == 0) begin
            sel_wr = 1;
            wdata = wdata | ($urandom & 32'hFF00_0000);
         end
         case ($urandom % 3)
            0: csr_rd = 1;
            1: sel_rd = 1;
            default: ;
         endcase
         if (($urandom % 20) == 0) pwr_dbg_ack = ~pwr_dbg_ack;
         if (($urandom % 20) == 0) pwr_sys_ack = ~pwr_sys_ack;
         step();
      end

      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

endmodule